// File: doc/BRIEF.md
# Flash Manufacturer ID Reader

This block runs the identification flow of a parallel NOR flash and judges the result. On `start` it asks an external command sequencer to put the flash into identification mode. It then waits a settle time set by a parameter and reads the manufacturer byte at offset 0x000 and the device byte at offset 0x001. A byte equal to the continuation code 0x7F is widened by exactly one more byte: 0x100 for the manufacturer ID, 0x101 for the device ID. The block then asks the sequencer to leave identification mode, waits a second, shorter settle time, and re-reads the same offsets under the same continuation rule. This re-read returns the normal array contents.

At the end the block presents the two 16-bit IDs and a match flag against the expected IDs captured at start. It also presents a parity warning for the low manufacturer byte and two flags that show whether each ID equals the normal array contents. The last two flags catch a device that never entered identification mode. Command encoding and bus timing belong to the sequencer. This block only issues two abstract commands and single-byte reads, each held until acknowledged.

The controller is one enumerated state machine:

| Step | States |
|---|---|
| Idle | IDLE |
| Identification mode | ENTER, ENTER_WAIT, RD_MFR, RD_DEV, RD_MFR_EXT, RD_DEV_EXT |
| Leaving and re-read | LEAVE, LEAVE_WAIT, RR_MFR, RR_DEV, RR_MFR_EXT, RR_DEV_EXT |
| Completion | FINISH |

The transitions are as follows:

- **Start:** IDLE goes to ENTER on `start`.
- **Commands:** ENTER goes to ENTER_WAIT on `cmd_ack`, and LEAVE goes to LEAVE_WAIT on `cmd_ack`.
- **Settle:** each wait state goes to its first read (RD_MFR or RR_MFR) when the settle timer reaches zero.
- **First byte:** each read state advances on `rd_valid`. RD_MFR goes to RD_DEV.
- **Second byte:** RD_DEV goes to RD_MFR_EXT if the manufacturer byte was 0x7F. Otherwise it goes to RD_DEV_EXT if the device byte is 0x7F. Otherwise it goes to LEAVE.
- **Manufacturer continuation:** RD_MFR_EXT goes to RD_DEV_EXT if the device byte was 0x7F, otherwise to LEAVE.
- **Re-read:** the RR_ states follow the same pattern and end in FINISH instead of LEAVE.
- **Completion:** FINISH returns to IDLE.

Top module: `flash_id_reader`

## Requirements
- R1: After reset `busy`, `done`, `cmd_req`, `rd_req`, `id_match`, `parity_warn`, both array flags and both IDs are 0.
- R2: A `start` pulse while idle raises `cmd_req` with `cmd_op`=0 (enter identification mode). A `start` while `busy` is 1 is ignored and begins no second run.
- R3: The first read request after the enter command is acknowledged rises exactly ENTRY_CYC cycles after the acknowledging cycle.
- R4: In identification mode the block reads offset 0x000 and then 0x001. A byte other than 0x7F becomes an ID with upper byte 0x00.
- R5: A manufacturer byte of 0x7F causes a read of 0x100, and the ID becomes 0x7F in the upper byte and the new byte in the lower byte. A device byte of 0x7F does the same with 0x101. These reads follow 0x001 in the order 0x100 then 0x101. Only one continuation level is followed, so a second 0x7F is kept as the low byte.
- R6: After the reads the block issues `cmd_op`=1 (leave identification mode). The first re-read rises exactly EXIT_CYC cycles after its acknowledging cycle. The re-read covers 0x000, 0x001 and the continuation offsets under the R5 rule.
- R7: `parity_warn` is 1 when the low byte of the manufacturer ID holds an even number of ones. The flow still completes.
- R8: `mfr_is_array` (`dev_is_array`) is 1 when the manufacturer (device) ID equals the value re-read after leaving identification mode.
- R9: `id_match` is 1 only when both IDs equal `exp_mfr` and `exp_dev` as sampled in the cycle `start` was accepted. Later changes of those inputs have no effect.
- R10: `done` is a single-cycle pulse in the cycle the results first appear. The outputs `mfr_id`, `dev_id`, `id_match`, `parity_warn`, `mfr_is_array` and `dev_is_array` change only in a `done` cycle.
- R11: `cmd_req` and `rd_req` are never high together. Each is held, with `cmd_op` or `rd_addr` unchanged, until its `cmd_ack` or `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an identification run |
| exp_mfr | input | 16 | Expected manufacturer ID, sampled at start |
| exp_dev | input | 16 | Expected device ID, sampled at start |
| cmd_req | output | 1 | Command request to the sequencer |
| cmd_op | output | 1 | 0 enter identification mode, 1 leave it |
| cmd_ack | input | 1 | Sequencer finished the command |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | ADDR_W | Byte offset of the read |
| rd_valid | input | 1 | Read data valid, ends the request |
| rd_data | input | 8 | Byte read from the flash |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse, results valid |
| mfr_id | output | 16 | Extended manufacturer ID |
| dev_id | output | 16 | Extended device ID |
| id_match | output | 1 | Both IDs equal the expected values |
| parity_warn | output | 1 | Low manufacturer byte has even parity |
| mfr_is_array | output | 1 | Manufacturer ID equals normal array contents |
| dev_is_array | output | 1 | Device ID equals normal array contents |

## Verification
A wrong state in the controller shows at the read port first. A skipped or extra continuation state gives a wrong `rd_addr` sequence within one read latency, before `done` is ever reached. A timer loaded with the wrong value moves the rise of the first read request relative to the command acknowledge, and so shows one settle period after each command. Misrouted capture registers appear only in the `done` cycle, as a wrong ID, match, parity or array flag. They show as late as the end of the run, so every run compares all six result outputs at that pulse.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;

    localparam int BYTE_W = 8;
    localparam int ID_W   = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] CONT_CODE = 8'h7F;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ENTER,
        S_ENTER_WAIT,
        S_RD_MFR,
        S_RD_DEV,
        S_RD_MFR_EXT,
        S_RD_DEV_EXT,
        S_LEAVE,
        S_LEAVE_WAIT,
        S_RR_MFR,
        S_RR_DEV,
        S_RR_MFR_EXT,
        S_RR_DEV_EXT,
        S_FINISH
    } fid_state_t;

    typedef enum logic {
        OP_ENTER = 1'b0,
        OP_LEAVE = 1'b1
    } fid_op_t;

endpackage

// File: rtl/flash_id_timer.sv
module flash_id_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= value;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/flash_id_parity.sv
module flash_id_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    output logic         odd
);

    logic [W-1:0] fold;

    assign fold[0] = data[0];

    generate
        for (genvar i = 1; i < W; i++) begin : g_fold
            assign fold[i] = fold[i-1] ^ data[i];
        end
    endgenerate

    assign odd = fold[W-1];

endmodule

// File: rtl/flash_id_fsm.sv
module flash_id_fsm
    import flash_id_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_ack,
    input  logic              rd_valid,
    input  logic              byte_cont,
    input  logic              mfr_cont,
    input  logic              dev_cont,
    input  logic              amfr_cont,
    input  logic              adev_cont,
    input  logic              tmr_zero,
    output fid_state_t        state,
    output logic              cmd_req,
    output logic              cmd_op,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              tmr_load,
    output logic              tmr_leave,
    output logic              finish
);

    localparam logic [ADDR_W-1:0] OFS_MFR   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_DEV   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_MFR_X = ADDR_W'(256);
    localparam logic [ADDR_W-1:0] OFS_DEV_X = ADDR_W'(257);

    fid_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:       if (start) nxt = S_ENTER;
            S_ENTER:      if (cmd_ack) nxt = S_ENTER_WAIT;
            S_ENTER_WAIT: if (tmr_zero) nxt = S_RD_MFR;
            S_RD_MFR:     if (rd_valid) nxt = S_RD_DEV;
            S_RD_DEV: begin
                if (rd_valid) begin
                    if (mfr_cont)       nxt = S_RD_MFR_EXT;
                    else if (byte_cont) nxt = S_RD_DEV_EXT;
                    else                nxt = S_LEAVE;
                end
            end
            S_RD_MFR_EXT: begin
                if (rd_valid) nxt = dev_cont ? S_RD_DEV_EXT : S_LEAVE;
            end
            S_RD_DEV_EXT: if (rd_valid) nxt = S_LEAVE;
            S_LEAVE:      if (cmd_ack) nxt = S_LEAVE_WAIT;
            S_LEAVE_WAIT: if (tmr_zero) nxt = S_RR_MFR;
            S_RR_MFR:     if (rd_valid) nxt = S_RR_DEV;
            S_RR_DEV: begin
                if (rd_valid) begin
                    if (amfr_cont)      nxt = S_RR_MFR_EXT;
                    else if (byte_cont) nxt = S_RR_DEV_EXT;
                    else                nxt = S_FINISH;
                end
            end
            S_RR_MFR_EXT: begin
                if (rd_valid) nxt = adev_cont ? S_RR_DEV_EXT : S_FINISH;
            end
            S_RR_DEV_EXT: if (rd_valid) nxt = S_FINISH;
            S_FINISH:     nxt = S_IDLE;
            default:      nxt = S_IDLE;
        endcase
    end

    always_comb begin
        cmd_req   = 1'b0;
        cmd_op    = OP_ENTER;
        rd_req    = 1'b0;
        rd_addr   = OFS_MFR;
        tmr_load  = 1'b0;
        tmr_leave = 1'b0;
        finish    = 1'b0;
        unique case (state)
            S_ENTER: begin
                cmd_req  = 1'b1;
                cmd_op   = OP_ENTER;
                tmr_load = cmd_ack;
            end
            S_LEAVE: begin
                cmd_req   = 1'b1;
                cmd_op    = OP_LEAVE;
                tmr_load  = cmd_ack;
                tmr_leave = 1'b1;
            end
            S_RD_MFR, S_RR_MFR: begin
                rd_req  = 1'b1;
                rd_addr = OFS_MFR;
            end
            S_RD_DEV, S_RR_DEV: begin
                rd_req  = 1'b1;
                rd_addr = OFS_DEV;
            end
            S_RD_MFR_EXT, S_RR_MFR_EXT: begin
                rd_req  = 1'b1;
                rd_addr = OFS_MFR_X;
            end
            S_RD_DEV_EXT, S_RR_DEV_EXT: begin
                rd_req  = 1'b1;
                rd_addr = OFS_DEV_X;
            end
            S_FINISH: finish = 1'b1;
            default: ;
        endcase
    end

    // R11: the sequencer never sees a command and a read at once
    p_req_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_req && rd_req));

    // R11: a read request holds its address until data arrives
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    // R11: a command request holds its opcode until acknowledged
    p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_op)));

    // R3: the first read in identification mode waits for the timer
    p_enter_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD_MFR && $past(state) == S_ENTER_WAIT) |-> $past(tmr_zero));

    // R6: the first re-read waits for the timer
    p_leave_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RR_MFR && $past(state) == S_LEAVE_WAIT) |-> $past(tmr_zero));

endmodule

// File: rtl/flash_id_reader.sv
module flash_id_reader
    import flash_id_pkg::*;
#(
    parameter int ENTRY_CYC = 1250000,
    parameter int EXIT_CYC  = 5000,
    parameter int ADDR_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       exp_mfr,
    input  logic [15:0]       exp_dev,
    output logic              cmd_req,
    output logic              cmd_op,
    input  logic              cmd_ack,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic [15:0]       mfr_id,
    output logic [15:0]       dev_id,
    output logic              id_match,
    output logic              parity_warn,
    output logic              mfr_is_array,
    output logic              dev_is_array
);

    localparam int MAX_CYC = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [ID_W-1:0] CONT_ONLY = {{BYTE_W{1'b0}}, CONT_CODE};

    fid_state_t       state;
    logic             tmr_load, tmr_leave, tmr_zero, finish;
    logic [CNT_W-1:0] tmr_value;
    logic [ID_W-1:0]  mfr_r, dev_r, amfr_r, adev_r;
    logic [ID_W-1:0]  exp_mfr_q, exp_dev_q;
    logic             low_odd;

    assign tmr_value = tmr_leave ? CNT_W'(EXIT_CYC - 1) : CNT_W'(ENTRY_CYC - 1);

    flash_id_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_ack   (cmd_ack),
        .rd_valid  (rd_valid),
        .byte_cont (rd_data == CONT_CODE),
        .mfr_cont  (mfr_r == CONT_ONLY),
        .dev_cont  (dev_r == CONT_ONLY),
        .amfr_cont (amfr_r == CONT_ONLY),
        .adev_cont (adev_r == CONT_ONLY),
        .tmr_zero  (tmr_zero),
        .state     (state),
        .cmd_req   (cmd_req),
        .cmd_op    (cmd_op),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .tmr_load  (tmr_load),
        .tmr_leave (tmr_leave),
        .finish    (finish)
    );

    flash_id_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .value (tmr_value),
        .zero  (tmr_zero)
    );

    flash_id_parity #(.W(BYTE_W)) u_parity (
        .data (mfr_r[BYTE_W-1:0]),
        .odd  (low_odd)
    );

    assign busy = (state != S_IDLE);

    // byte capture, one register pair per phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mfr_r  <= '0;
            dev_r  <= '0;
            amfr_r <= '0;
            adev_r <= '0;
        end else if (rd_valid) begin
            unique case (state)
                S_RD_MFR:     mfr_r  <= {{BYTE_W{1'b0}}, rd_data};
                S_RD_DEV:     dev_r  <= {{BYTE_W{1'b0}}, rd_data};
                S_RD_MFR_EXT: mfr_r  <= {mfr_r[BYTE_W-1:0], rd_data};
                S_RD_DEV_EXT: dev_r  <= {dev_r[BYTE_W-1:0], rd_data};
                S_RR_MFR:     amfr_r <= {{BYTE_W{1'b0}}, rd_data};
                S_RR_DEV:     adev_r <= {{BYTE_W{1'b0}}, rd_data};
                S_RR_MFR_EXT: amfr_r <= {amfr_r[BYTE_W-1:0], rd_data};
                S_RR_DEV_EXT: adev_r <= {adev_r[BYTE_W-1:0], rd_data};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_mfr_q <= '0;
            exp_dev_q <= '0;
        end else if (start && state == S_IDLE) begin
            exp_mfr_q <= exp_mfr;
            exp_dev_q <= exp_dev;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done         <= 1'b0;
            mfr_id       <= '0;
            dev_id       <= '0;
            id_match     <= 1'b0;
            parity_warn  <= 1'b0;
            mfr_is_array <= 1'b0;
            dev_is_array <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                mfr_id       <= mfr_r;
                dev_id       <= dev_r;
                id_match     <= (mfr_r == exp_mfr_q) && (dev_r == exp_dev_q);
                parity_warn  <= ~low_odd;
                mfr_is_array <= (mfr_r == amfr_r);
                dev_is_array <= (dev_r == adev_r);
            end
        end
    end

    // R10: done lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: results move only with done
    p_out_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(mfr_id) && $stable(dev_id) && $stable(id_match) &&
                   $stable(parity_warn) && $stable(mfr_is_array) && $stable(dev_is_array)));

    // R5: an extended ID carries either no prefix or one continuation code
    p_ext_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mfr_id[ID_W-1:BYTE_W] == '0 || mfr_id[ID_W-1:BYTE_W] == CONT_CODE));

    // R9: a reported match implies equality with the captured expectation
    p_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && id_match) |-> (mfr_id == exp_mfr_q && dev_id == exp_dev_q));

endmodule

// File: tb/test_flash_id_reader.sv
module test_flash_id_reader;

    localparam int TB_ENTRY = 37;
    localparam int TB_EXIT  = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] exp_mfr = '0, exp_dev = '0;
    logic        cmd_req, cmd_op, rd_req, busy, done;
    logic        cmd_ack = 1'b0, rd_valid = 1'b0;
    logic [8:0]  rd_addr;
    logic [7:0]  rd_data = '0;
    logic [15:0] mfr_id, dev_id;
    logic        id_match, parity_warn, mfr_is_array, dev_is_array;

    int vectors = 0, errors = 0;
    int cyc = 0;

    // flash model
    logic       idmode = 1'b0;
    logic [7:0] id_b0, id_b1, id_c0, id_c1, ar_b0, ar_b1, ar_c0, ar_c1;
    logic [8:0] alog [0:15];
    int         tlog [0:15];
    int         an = 0;
    logic       oplog [0:3];
    int         tcmd [0:3];
    int         cn = 0;

    flash_id_reader #(.ENTRY_CYC(TB_ENTRY), .EXIT_CYC(TB_EXIT), .ADDR_W(9)) i_flash_id_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .exp_mfr(exp_mfr), .exp_dev(exp_dev),
        .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_ack(cmd_ack),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .done(done), .mfr_id(mfr_id), .dev_id(dev_id), .id_match(id_match),
        .parity_warn(parity_warn), .mfr_is_array(mfr_is_array), .dev_is_array(dev_is_array)
    );

    initial forever #4 clk = ~clk;
    initial forever begin @(posedge clk); cyc++; end

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        vectors++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_up();
    end

    function automatic logic [7:0] mem_rd(logic [8:0] a);
        if (idmode) begin
            case (a)
                9'h000: return id_b0;
                9'h001: return id_b1;
                9'h100: return id_c0;
                9'h101: return id_c1;
                default: return 8'hEE;
            endcase
        end else begin
            case (a)
                9'h000: return ar_b0;
                9'h001: return ar_b1;
                9'h100: return ar_c0;
                9'h101: return ar_c1;
                default: return 8'hEE;
            endcase
        end
    endfunction

    // command sequencer model
    initial forever begin
        @(negedge clk);
        if (cmd_req) begin
            if (cn < 4) oplog[cn] = cmd_op;
            repeat (2) @(negedge clk);
            cmd_ack = 1'b1;
            if (cn < 4) tcmd[cn] = cyc;
            idmode = (cmd_op == 1'b0);
            @(negedge clk);
            cmd_ack = 1'b0;
            cn++;
        end
    end

    // read port model
    initial forever begin
        @(negedge clk);
        if (rd_req) begin
            if (an < 16) begin
                alog[an] = rd_addr;
                tlog[an] = cyc;
            end
            @(negedge clk);
            rd_data  = mem_rd(rd_addr);
            rd_valid = 1'b1;
            @(negedge clk);
            rd_valid = 1'b0;
            an++;
        end
    end

    function automatic logic [15:0] ext(logic [7:0] b, logic [7:0] c);
        return (b == 8'h7F) ? {8'h7F, c} : {8'h00, b};
    endfunction

    // full run with all result checks; disturb pulses start and changes exp mid-run
    task automatic do_run(string tag, logic [15:0] em, logic [15:0] ed, logic disturb);
        logic [15:0] xm, xd, am, ad;
        logic [8:0]  xa [0:7];
        int          xn, nid, n;
        an = 0; cn = 0;
        exp_mfr = em; exp_dev = ed;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check({tag, " R2 enter op"}, {31'd0, cmd_op}, 32'd0);
        check({tag, " R2 cmd_req"}, {31'd0, cmd_req}, 32'd1);
        if (disturb) begin
            repeat (5) @(negedge clk);
            start = 1'b1; exp_mfr = ~em; exp_dev = ~ed;
            @(negedge clk); start = 1'b0;
        end
        n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        check({tag, " done seen"}, {31'd0, done}, 32'd1);
        xm = ext(id_b0, id_c0); xd = ext(id_b1, id_c1);
        am = ext(ar_b0, ar_c0); ad = ext(ar_b1, ar_c1);
        check({tag, " R4 R5 mfr_id"}, {16'd0, mfr_id}, {16'd0, xm});
        check({tag, " R4 R5 dev_id"}, {16'd0, dev_id}, {16'd0, xd});
        check({tag, " R9 match"}, {31'd0, id_match}, {31'd0, (xm == em) && (xd == ed)});
        check({tag, " R7 parity"}, {31'd0, parity_warn}, {31'd0, ~(^xm[7:0])});
        check({tag, " R8 mfr array"}, {31'd0, mfr_is_array}, {31'd0, xm == am});
        check({tag, " R8 dev array"}, {31'd0, dev_is_array}, {31'd0, xd == ad});
        // expected read order
        xn = 0;
        xa[xn++] = 9'h000; xa[xn++] = 9'h001;
        if (id_b0 == 8'h7F) xa[xn++] = 9'h100;
        if (id_b1 == 8'h7F) xa[xn++] = 9'h101;
        nid = xn;
        xa[xn++] = 9'h000; xa[xn++] = 9'h001;
        if (ar_b0 == 8'h7F) xa[xn++] = 9'h100;
        if (ar_b1 == 8'h7F) xa[xn++] = 9'h101;
        check({tag, " R5 R6 read count"}, an, xn);
        for (int i = 0; i < xn; i++)
            check({tag, " R4 R5 R6 read addr"}, {23'd0, alog[i]}, {23'd0, xa[i]});
        check({tag, " R6 op count"}, cn, 2);
        check({tag, " R6 leave op"}, {31'd0, oplog[1]}, 32'd1);
        check({tag, " R3 entry settle"}, tlog[0] - tcmd[0] - 1, TB_ENTRY);
        check({tag, " R6 exit settle"}, tlog[nid] - tcmd[1] - 1, TB_EXIT);
        @(negedge clk);
        check({tag, " R10 done single"}, {31'd0, done}, 32'd0);
        repeat (6) @(negedge clk);
        check({tag, " R2 idle after"}, {30'd0, busy, cmd_req}, 32'd0);
        check({tag, " R2 no second run"}, cn, 2);
    endtask

    task automatic set_mem(logic [7:0] b0, c0, b1, c1, a0, ac0, a1, ac1);
        id_b0 = b0; id_c0 = c0; id_b1 = b1; id_c1 = c1;
        ar_b0 = a0; ar_c0 = ac0; ar_b1 = a1; ar_c1 = ac1;
    endtask

    task automatic t_reset();
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 requests", {30'd0, cmd_req, rd_req}, 32'd0);
        check("R1 ids", {mfr_id, dev_id}, 32'd0);
        check("R1 flags", {28'd0, id_match, parity_warn, mfr_is_array, dev_is_array}, 32'd0);
    endtask

    task automatic t_plain();
        set_mem(8'hBF, 8'h00, 8'hB6, 8'h00, 8'h12, 8'h00, 8'h34, 8'h00);
        do_run("plain", 16'h00BF, 16'h00B6, 1'b0);
    endtask

    task automatic t_mismatch();
        set_mem(8'hBF, 8'h00, 8'hB6, 8'h00, 8'h12, 8'h00, 8'h34, 8'h00);
        do_run("mismatch", 16'h00BF, 16'h00B7, 1'b0);
    endtask

    task automatic t_mfr_cont();
        set_mem(8'h7F, 8'h9D, 8'h20, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00);
        do_run("mfr_cont", 16'h7F9D, 16'h0020, 1'b0);
    endtask

    task automatic t_both_cont();
        set_mem(8'h7F, 8'h03, 8'h7F, 8'h55, 8'h7F, 8'h01, 8'h7F, 8'h55);
        do_run("both_cont", 16'h7F03, 16'h7F55, 1'b0);
    endtask

    task automatic t_false_id();
        set_mem(8'h12, 8'h00, 8'h34, 8'h00, 8'h12, 8'h00, 8'h34, 8'h00);
        do_run("false_id", 16'h0012, 16'h0034, 1'b0);
    endtask

    task automatic t_double_cont();
        set_mem(8'h7F, 8'h7F, 8'h40, 8'h7F, 8'h00, 8'h00, 8'h01, 8'h00);
        do_run("double_cont", 16'h7F7F, 16'h0040, 1'b0);
    endtask

    task automatic t_busy_start();
        set_mem(8'h1F, 8'h00, 8'h7F, 8'hC2, 8'h00, 8'h00, 8'h00, 8'h00);
        do_run("busy_start", 16'h001F, 16'h7FC2, 1'b1);
    endtask

    task automatic t_stable();
        logic [15:0] pm, pd;
        logic [3:0]  pf;
        pm = mfr_id; pd = dev_id;
        pf = {id_match, parity_warn, mfr_is_array, dev_is_array};
        exp_mfr = 16'hAAAA; exp_dev = 16'h5555;
        set_mem(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08);
        repeat (30) @(negedge clk);
        check("R10 stable ids", {mfr_id, dev_id}, {pm, pd});
        check("R10 stable flags",
              {28'd0, id_match, parity_warn, mfr_is_array, dev_is_array}, {28'd0, pf});
    endtask

    initial begin
        set_mem(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_plain();
        t_mismatch();
        t_mfr_cont();
        t_both_cont();
        t_false_id();
        t_double_cont();
        t_busy_start();
        t_stable();
        finish_up();
    end

endmodule